// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block sits between instruction fetch and issue in a two-wide in-order pipeline. Each fetch delivers a pair of instructions. The left slot carries an integer-side instruction (an ALU op, a load, a store or a branch). The right slot is meant for a floating-point operation. From the decoded class and register fields of both slots, the block decides in the same cycle whether to issue both instructions, only the left one, or none. It raises a hold toward fetch whenever some instruction of the presented pair has not issued yet.

Three rules decide issue:
- Slot class: a pair issues together only when the right slot holds an FP operation and the left slot does not.
- Order: the right instruction never issues ahead of the left one. When the left instruction issues alone, the pair stays on the inputs and the right instruction is examined on its own as the next first instruction.
- Load delay: the block keeps the destinations of any loads that issued in the previous cycle. A reader of such a destination, in either slot, waits one cycle. Together with the partner rule, this makes a load's delay cover its partner slot and both slots of the following pair.

Top module: `pair_issue_gate`

## Requirements
- R1: While `rst_n` is low, `issue_l`, `issue_r` and `fetch_hold` are 0. After reset, no load destination is recorded and no half-issued pair is pending.
- R2: A valid pair issues as a whole in the cycle it is presented (`issue_l`=`issue_r`=1, `fetch_hold`=0) when all of these hold:
  - the right class is FP op (code 5) and the left class is not;
  - the right slot reads no register the left slot writes;
  - neither slot reads a load destination recorded from the previous cycle.
- R3: If the right class is not FP op, or the left class is FP op, only the left instruction issues and `fetch_hold` is 1. In the next cycle, with the same pair still presented, only the right instruction is considered (`issue_l`=0). It issues with `fetch_hold`=0 when free of hazards.
- R4: If the right slot reads (through an enabled source) the register the left slot writes, only the left instruction issues.
- R5: When the left instruction of a freshly presented pair does not issue, the right one does not issue either, even if it is free of hazards.
- R6: A load (class 1 integer load or class 2 FP load) that issues with its destination enabled blocks, in the next cycle, any instruction that reads that destination. If that instruction is in the left slot, nothing issues and `fetch_hold` is 1.
- R7: If only the right slot reads a recorded load destination, the left instruction issues and the right is held for the next cycle.
- R8: The load record covers exactly one cycle. A reader stalled by it issues in the following cycle.
- R9: An FP load in the left slot and an independent FP op in the right slot issue together.
- R10: While `pkt_valid` is 0, nothing issues and `fetch_hold` is 0. Since nothing issued, the load record is empty in the next cycle.
- R11: Register tags are 6 bits: bit 5 selects the FP bank (1) or the integer bank (0), and bits 4:0 give the index. Equal indices in different banks are not a dependence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_valid | input | 1 | A fetch pair is presented |
| l_cls | input | 3 | Left class: 0 int ALU, 1 int load, 2 FP load, 3 store, 4 branch, 5 FP op |
| l_dst | input | 6 | Left destination tag |
| l_dst_we | input | 1 | Left slot writes `l_dst` |
| l_srca | input | 6 | Left first source tag |
| l_srca_re | input | 1 | Left reads `l_srca` |
| l_srcb | input | 6 | Left second source tag |
| l_srcb_re | input | 1 | Left reads `l_srcb` |
| r_cls | input | 3 | Right class, same encoding |
| r_dst | input | 6 | Right destination tag |
| r_dst_we | input | 1 | Right slot writes `r_dst` |
| r_srca | input | 6 | Right first source tag |
| r_srca_re | input | 1 | Right reads `r_srca` |
| r_srcb | input | 6 | Right second source tag |
| r_srcb_re | input | 1 | Right reads `r_srcb` |
| issue_l | output | 1 | Left instruction issues this cycle |
| issue_r | output | 1 | Right instruction issues this cycle |
| fetch_hold | output | 1 | Keep the current pair on the inputs next cycle |

## Verification
The three outputs are combinational. They answer a presented pair in the same cycle, from the inputs and from state captured at the last rising edge. The bench therefore drives each pair just after a falling edge and samples the outputs shortly after, before the next rising edge. The load record and the pending-right state take effect one rising edge after the issuing cycle. Each scenario task checks the follow-up behaviour (stall, single right issue, cleared record) at the next falling-edge sample, and again one cycle later where a stall must end.

// File: rtl/pair_issue_gate.sv
module pair_issue_gate #(
  parameter int REG_W = 5,
  parameter int CLS_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pkt_valid,
  input  logic [CLS_W-1:0]   l_cls,
  input  logic [REG_W:0]     l_dst,
  input  logic               l_dst_we,
  input  logic [REG_W:0]     l_srca,
  input  logic               l_srca_re,
  input  logic [REG_W:0]     l_srcb,
  input  logic               l_srcb_re,
  input  logic [CLS_W-1:0]   r_cls,
  input  logic [REG_W:0]     r_dst,
  input  logic               r_dst_we,
  input  logic [REG_W:0]     r_srca,
  input  logic               r_srca_re,
  input  logic [REG_W:0]     r_srcb,
  input  logic               r_srcb_re,
  output logic               issue_l,
  output logic               issue_r,
  output logic               fetch_hold
);
  localparam int TAG_W = REG_W + 1;
  localparam logic [CLS_W-1:0] C_ILD  = CLS_W'(1);
  localparam logic [CLS_W-1:0] C_FLD  = CLS_W'(2);
  localparam logic [CLS_W-1:0] C_FPOP = CLS_W'(5);

  function automatic logic reads(input logic v, input logic [TAG_W-1:0] t,
                                 input logic [TAG_W-1:0] a, input logic ae,
                                 input logic [TAG_W-1:0] b, input logic be);
    return v && ((ae && a == t) || (be && b == t));
  endfunction

  logic             left_done;
  logic             rec0_v, rec1_v;
  logic [TAG_W-1:0] rec0_tag, rec1_tag;

  wire active  = rst_n && pkt_valid;
  wire l_is_fp = (l_cls == C_FPOP);
  wire r_is_fp = (r_cls == C_FPOP);
  wire l_is_ld = (l_cls == C_ILD) || (l_cls == C_FLD);
  wire r_is_ld = (r_cls == C_ILD) || (r_cls == C_FLD);

  wire l_lu = reads(rec0_v, rec0_tag, l_srca, l_srca_re, l_srcb, l_srcb_re) ||
              reads(rec1_v, rec1_tag, l_srca, l_srca_re, l_srcb, l_srcb_re);
  wire r_lu = reads(rec0_v, rec0_tag, r_srca, r_srca_re, r_srcb, r_srcb_re) ||
              reads(rec1_v, rec1_tag, r_srca, r_srca_re, r_srcb, r_srcb_re);
  wire r_dep = reads(l_dst_we, l_dst, r_srca, r_srca_re, r_srcb, r_srcb_re);
  wire pair_ok = r_is_fp && !l_is_fp && !r_dep;

  assign issue_l    = active && !left_done && !l_lu;
  assign issue_r    = active && !r_lu && (left_done || (issue_l && pair_ok));
  assign fetch_hold = active && !issue_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_done <= 1'b0;
      rec0_v    <= 1'b0;
      rec1_v    <= 1'b0;
      rec0_tag  <= '0;
      rec1_tag  <= '0;
    end else begin
      if (active) begin
        if (issue_r)      left_done <= 1'b0;
        else if (issue_l) left_done <= 1'b1;
      end
      rec0_v   <= issue_l && l_is_ld && l_dst_we;
      rec1_v   <= issue_r && r_is_ld && r_dst_we;
      rec0_tag <= l_dst;
      rec1_tag <= r_dst;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> !issue_l && !issue_r && !fetch_hold); // R10
  AST_PAIR_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    issue_l && issue_r |-> r_cls == C_FPOP && l_cls != C_FPOP); // R2
  AST_PARTNER_DEP: assert property (@(posedge clk) disable iff (!rst_n)
    issue_l && issue_r && l_dst_we |-> !(r_srca_re && r_srca == l_dst)); // R4
  AST_LEFT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_l && !issue_r |=> !issue_l); // R3
  AST_LOAD_USE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_l && l_srca_re && $past(issue_l && l_is_ld && l_dst_we) |->
      l_srca != $past(l_dst)); // R6
endmodule

// File: tb/pair_issue_gate_tb_top.sv
module pair_issue_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] ALU = 3'd0, ILD = 3'd1, FLD = 3'd2, STO = 3'd3, FOP = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0, pkt_valid = 1'b0;
  logic [2:0] l_cls = '0, r_cls = '0;
  logic [5:0] l_dst = '0, l_srca = '0, l_srcb = '0, r_dst = '0, r_srca = '0, r_srcb = '0;
  logic l_dst_we = 0, l_srca_re = 0, l_srcb_re = 0, r_dst_we = 0, r_srca_re = 0, r_srcb_re = 0;
  logic issue_l, issue_r, fetch_hold;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_issue_gate dut_i (.clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
    .l_cls(l_cls), .l_dst(l_dst), .l_dst_we(l_dst_we), .l_srca(l_srca), .l_srca_re(l_srca_re),
    .l_srcb(l_srcb), .l_srcb_re(l_srcb_re),
    .r_cls(r_cls), .r_dst(r_dst), .r_dst_we(r_dst_we), .r_srca(r_srca), .r_srca_re(r_srca_re),
    .r_srcb(r_srcb), .r_srcb_re(r_srcb_re),
    .issue_l(issue_l), .issue_r(issue_r), .fetch_hold(fetch_hold));

  function automatic logic [5:0] ir(input int n); return {1'b0, 5'(n)}; endfunction
  function automatic logic [5:0] fr(input int n); return {1'b1, 5'(n)}; endfunction

  task automatic setl(input logic [2:0] c, input logic [5:0] d, input logic we,
                      input logic [5:0] a, input logic ae, input logic [5:0] b, input logic be);
    l_cls = c; l_dst = d; l_dst_we = we; l_srca = a; l_srca_re = ae; l_srcb = b; l_srcb_re = be;
  endtask
  task automatic setr(input logic [2:0] c, input logic [5:0] d, input logic we,
                      input logic [5:0] a, input logic ae, input logic [5:0] b, input logic be);
    r_cls = c; r_dst = d; r_dst_we = we; r_srca = a; r_srca_re = ae; r_srcb = b; r_srcb_re = be;
  endtask

  task automatic chk(input logic el, input logic er, input logic eh, input string req);
    nchk++;
    if (issue_l !== el || issue_r !== er || fetch_hold !== eh) begin
      nerr++;
      $display("FAIL %s: got l=%b r=%b h=%b expected l=%b r=%b h=%b",
               req, issue_l, issue_r, fetch_hold, el, er, eh);
    end
  endtask

  task automatic cyc_valid(); @(negedge clk); pkt_valid = 1'b1; endtask
  task automatic idle(); @(negedge clk); pkt_valid = 1'b0; endtask

  task automatic t_reset();
    pkt_valid = 1'b1;
    setl(ALU, ir(1), 1, ir(2), 1, ir(3), 1);
    setr(FOP, fr(1), 1, fr(2), 1, fr(3), 1);
    #1 chk(0, 0, 0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    #1 chk(1, 1, 0, "R1 clean state after reset");
    idle(); #1 chk(0, 0, 0, "R10 idle");
  endtask

  task automatic t_pair();
    cyc_valid();
    setl(ALU, ir(4), 1, ir(5), 1, ir(6), 1);
    setr(FOP, fr(4), 1, fr(5), 1, fr(6), 1);
    #1 chk(1, 1, 0, "R2 independent pair");
    idle();
  endtask

  task automatic t_class();
    cyc_valid();
    setl(ALU, ir(7), 1, ir(8), 1, ir(9), 0);
    setr(STO, ir(0), 0, ir(10), 1, fr(11), 1);
    #1 chk(1, 0, 1, "R3 right not FP op");
    cyc_valid(); #1 chk(0, 1, 0, "R3 right alone next");
    cyc_valid();
    setl(FOP, fr(12), 1, fr(13), 1, fr(14), 1);
    setr(FOP, fr(15), 1, fr(16), 1, fr(17), 1);
    #1 chk(1, 0, 1, "R3 left FP op");
    cyc_valid(); #1 chk(0, 1, 0, "R3 right alone next");
    idle();
  endtask

  task automatic t_partner();
    cyc_valid();
    setl(FLD, fr(20), 1, ir(1), 1, ir(0), 0);
    setr(FOP, fr(21), 1, fr(22), 1, fr(20), 1);
    #1 chk(1, 0, 1, "R4 right reads left dst");
    cyc_valid(); #1 chk(0, 0, 1, "R6 held right meets load delay");
    cyc_valid(); #1 chk(0, 1, 0, "R8 load delay over");
    idle();
    cyc_valid();
    setl(ALU, ir(23), 1, ir(24), 1, ir(0), 0);
    setr(FOP, fr(23), 1, fr(24), 1, fr(25), 1);
    #1 chk(1, 1, 0, "R4 write int r23 read fp f23 pairs");
    idle();
  endtask

  task automatic t_fpload_pair();
    cyc_valid();
    setl(FLD, fr(5), 1, ir(2), 1, ir(0), 0);
    setr(FOP, fr(6), 1, fr(7), 1, fr(8), 1);
    #1 chk(1, 1, 0, "R9 FP load with FP op");
    idle();
  endtask

  task automatic t_loaduse_left();
    cyc_valid();
    setl(ILD, ir(7), 1, ir(2), 1, ir(0), 0);
    setr(FOP, fr(9), 1, fr(10), 1, fr(11), 1);
    #1 chk(1, 1, 0, "R6 load pair");
    cyc_valid();
    setl(ALU, ir(12), 1, ir(13), 1, ir(7), 1);
    setr(FOP, fr(12), 1, fr(13), 1, fr(14), 1);
    #1 chk(0, 0, 1, "R5 R6 left stall blocks right");
    cyc_valid(); #1 chk(1, 1, 0, "R8 stall lasts one cycle");
    idle();
  endtask

  task automatic t_loaduse_right();
    cyc_valid();
    setl(FLD, fr(9), 1, ir(3), 1, ir(0), 0);
    setr(FOP, fr(15), 1, fr(16), 1, fr(17), 1);
    #1 chk(1, 1, 0, "R7 load pair");
    cyc_valid();
    setl(ALU, ir(18), 1, ir(19), 1, ir(20), 1);
    setr(FOP, fr(18), 1, fr(9), 1, fr(19), 1);
    #1 chk(1, 0, 1, "R7 right reads load dst");
    cyc_valid(); #1 chk(0, 1, 0, "R7 right issues next");
    idle();
  endtask

  task automatic t_bank();
    cyc_valid();
    setl(ILD, ir(3), 1, ir(4), 1, ir(0), 0);
    setr(FOP, fr(20), 1, fr(21), 1, fr(22), 1);
    #1 chk(1, 1, 0, "R11 int load pair");
    cyc_valid();
    setl(ALU, ir(5), 1, ir(4), 1, ir(6), 1);
    setr(FOP, fr(23), 1, fr(3), 1, fr(24), 1);
    #1 chk(1, 1, 0, "R11 fp f3 not int r3");
    idle();
  endtask

  task automatic t_idle();
    cyc_valid();
    setl(ILD, ir(10), 1, ir(11), 1, ir(0), 0);
    setr(FOP, fr(25), 1, fr(26), 1, fr(27), 1);
    #1 chk(1, 1, 0, "R10 load pair");
    idle(); #1 chk(0, 0, 0, "R10 no packet");
    cyc_valid();
    setl(ALU, ir(12), 1, ir(10), 1, ir(0), 0);
    setr(FOP, fr(28), 1, fr(29), 1, fr(30), 1);
    #1 chk(1, 1, 0, "R10 record cleared by idle");
    idle();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_pair();
    t_class();
    t_partner();
    t_fpload_pair();
    t_loaduse_left();
    t_loaduse_right();
    t_bank();
    t_idle();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      nerr++; nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule